// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the serial clock of an I2C master. A packed timing word carries three 4-bit fields:

- a prescale exponent, which divides the system clock by 2^exponent to form a prescale tick;
- a low-phase count, which sets how many of those ticks SCL is held low;
- a high-phase count, which sets how many ticks SCL is left released.

The block drives SCL through an open-drain drive-low enable. It watches the real SCL line, so a target that holds the clock low stretches the high phase. A byte engine beside it uses three one-cycle strobes: one where SCL actually goes high, one in the middle of the high phase for sampling SDA, and one just before SCL is pulled low again.

A run input starts and stops the clock. The block only leaves the bus clock at the end of a high phase, so a stop never cuts a period short. In the idle state the line is released and the prescaler is held at zero, so the first period after a start has full length. The timing word is captured each time a low phase begins. Any rewrite of the word therefore applies from the next low phase on.

Control is a four-state machine:

- **IDLE**: released, prescaler cleared.
- **LOW**: drive-low asserted.
- **RELEASE**: drive removed, waiting for the line to read high.
- **HIGH**: released and counting.

Transitions:

- IDLE→LOW when run is seen; the timing word is captured.
- LOW→RELEASE on the last tick of the low phase.
- RELEASE→HIGH in the first cycle the line reads high. That cycle is already the first high cycle.
- HIGH→LOW on the last high tick while run is high; the word is captured again.
- HIGH→IDLE on that tick while run is low. RELEASE may also take either exit directly when the high phase is a single system clock.

Top module: `scl_timing_gen`

## Requirements
- R1: The timing word is decoded with the high-phase count in bits 19:16, the low-phase count in bits 15:12 and the prescale exponent b in bits 3:0; bits 11:4 have no effect on any output.
- R2: Once started, the drive-low output stays asserted for exactly (low_count+1)·2^b consecutive system clocks per period.
- R3: With the line following the drive, SCL stays released for exactly (high_count+1)·2^b consecutive system clocks before drive-low asserts again.
- R4: Released cycles in which the sampled line is still low are not counted: a stretch of S cycles lengthens the released time to S+(high_count+1)·2^b and emits no strobe.
- R5: The rise strobe pulses exactly once per period, in the first released cycle in which the line reads high.
- R6: The mid strobe pulses exactly once per period, in the released cycle numbered ((high_count>>1)+1)·2^b counted from the rise strobe's cycle as 1.
- R7: The fall strobe pulses exactly once per continuing period, in the last released cycle, and drive-low asserts in the following cycle; no strobe fires while drive-low is asserted.
- R8: The timing word is captured when a low phase starts; a new word written during a period changes only the following period.
- R9: Run is acted on only from idle and at the end of a high phase. With run low the block finishes the high phase, then stays released with no strobes and emits no fall strobe. From idle, drive-low asserts on the clock edge that samples run high, and that period has full length.
- R10: During and after reset, with run low, drive-low is deasserted and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run (1) or hold (0) the bus clock |
| timing_word_i | input | 20 | Packed high count, low count and prescale exponent |
| scl_line_i | input | 1 | Sampled level of the SCL wire |
| scl_drive_low_o | output | 1 | Open-drain enable: 1 pulls SCL low |
| scl_rise_o | output | 1 | One-cycle strobe where SCL is seen high |
| scl_mid_o | output | 1 | One-cycle strobe in the middle of the high phase |
| scl_fall_o | output | 1 | One-cycle strobe in the cycle before SCL is pulled low |

## Verification
The bench measures every period at the ports and checks phase lengths and strobe positions against formulas built from the fields. It targets the following corner cases:

- **All-zero fields.** Rise, mid and fall collapse into one cycle. A design that counts an extra tick, or that drops one of the coincident strobes, shows up here.
- **Stretching.** The bench holds the line low after release. A design that counts during the stretch ends the high phase early and fires rise before the line is high.
- **Rewriting the word inside a period.** A design that reads the live word changes the current high phase.
- **Stopping during a low phase, then restarting.** A stop that truncates the period, emits a stray fall strobe, or leaves a stale prescale count in place gives wrong lengths.

// File: rtl/scl_tg_pkg.sv
`timescale 1ns/1ps
package scl_tg_pkg;
    parameter int unsigned TG_PH_W  = 4;
    parameter int unsigned TG_EXP_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HIGH    = 2'd3
    } tg_state_t;

    typedef struct packed {
        logic [TG_PH_W-1:0]  hi;
        logic [TG_PH_W-1:0]  lo;
        logic [TG_EXP_W-1:0] expo;
    } tg_timing_t;
endpackage

// File: rtl/scl_tg_unpack.sv
`timescale 1ns/1ps
module scl_tg_unpack
    import scl_tg_pkg::*;
#(
    parameter int unsigned WORD_W  = 20,
    parameter int unsigned HI_LSB  = 16,
    parameter int unsigned LO_LSB  = 12,
    parameter int unsigned EXP_LSB = 0
) (
    input  logic [WORD_W-1:0] word_i,
    output tg_timing_t        fields_o
);
    logic unused_bits;

    always_comb begin
        fields_o.hi   = word_i[HI_LSB  +: TG_PH_W];
        fields_o.lo   = word_i[LO_LSB  +: TG_PH_W];
        fields_o.expo = word_i[EXP_LSB +: TG_EXP_W];
    end

    // bits outside the three fields are deliberately dropped
    assign unused_bits = ^word_i;
endmodule

// File: rtl/scl_tg_prescaler.sv
`timescale 1ns/1ps
module scl_tg_prescaler #(
    parameter int unsigned EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [EXP_W-1:0] expo_i,
    output logic             tick_o
);
    localparam int unsigned CNT_W = 1 << EXP_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit  = (CNT_W'(1) << expo_i) - CNT_W'(1);
    assign tick_o = en_i && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/scl_tg_phase_fsm.sv
`timescale 1ns/1ps
module scl_tg_phase_fsm
    import scl_tg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                line_i,
    input  tg_timing_t          fields_i,
    input  logic                tick_i,
    output logic                drive_low_o,
    output logic                pre_en_o,
    output logic                pre_clr_o,
    output logic                rise_o,
    output logic                mid_o,
    output logic                fall_o,
    output logic [TG_EXP_W-1:0] expo_o,
    output tg_state_t           state_o,
    output tg_timing_t          lat_o
);
    tg_state_t          state_q, state_d;
    logic [TG_PH_W-1:0] ph_q, ph_d;
    tg_timing_t         lat_q;
    logic               load;

    logic high_cnt;
    logic lo_done;
    logic hi_done;

    assign high_cnt = (state_q == ST_HIGH) || ((state_q == ST_RELEASE) && line_i);
    assign lo_done  = (state_q == ST_LOW) && tick_i && (ph_q == lat_q.lo);
    assign hi_done  = high_cnt && tick_i && (ph_q == lat_q.hi);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            if (load) begin
                lat_q <= fields_i;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) begin
                    state_d = ST_LOW;
                    ph_d    = '0;
                    load    = 1'b1;
                end
            end
            ST_LOW: begin
                if (lo_done) begin
                    state_d = ST_RELEASE;
                    ph_d    = '0;
                end else if (tick_i) begin
                    ph_d = ph_q + 1'b1;
                end
            end
            ST_RELEASE, ST_HIGH: begin
                if (hi_done) begin
                    ph_d = '0;
                    if (run_i) begin
                        state_d = ST_LOW;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (high_cnt) begin
                    state_d = ST_HIGH;
                    if (tick_i) begin
                        ph_d = ph_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        drive_low_o = (state_q == ST_LOW);
        pre_en_o    = (state_q == ST_LOW) || high_cnt;
        pre_clr_o   = (state_q == ST_IDLE) || ((state_q == ST_RELEASE) && !line_i);
        rise_o      = (state_q == ST_RELEASE) && line_i;
        mid_o       = high_cnt && tick_i && (ph_q == (lat_q.hi >> 1));
        fall_o      = hi_done && run_i;
        expo_o      = lat_q.expo;
        state_o     = state_q;
        lat_o       = lat_q;
    end
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int unsigned WORD_W  = 20,
    parameter int unsigned HI_LSB  = 16,
    parameter int unsigned LO_LSB  = 12,
    parameter int unsigned EXP_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [WORD_W-1:0] timing_word_i,
    input  logic              scl_line_i,
    output logic              scl_drive_low_o,
    output logic              scl_rise_o,
    output logic              scl_mid_o,
    output logic              scl_fall_o
);
    tg_timing_t          fields;
    tg_timing_t          lat;
    tg_state_t           st;
    logic                pre_en;
    logic                pre_clr;
    logic                tick;
    logic [TG_EXP_W-1:0] expo;

    scl_tg_unpack #(
        .WORD_W (WORD_W),
        .HI_LSB (HI_LSB),
        .LO_LSB (LO_LSB),
        .EXP_LSB(EXP_LSB)
    ) u_unpack (
        .word_i  (timing_word_i),
        .fields_o(fields)
    );

    scl_tg_prescaler #(
        .EXP_W(TG_EXP_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (pre_en),
        .clr_i (pre_clr),
        .expo_i(expo),
        .tick_o(tick)
    );

    scl_tg_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .line_i     (scl_line_i),
        .fields_i   (fields),
        .tick_i     (tick),
        .drive_low_o(scl_drive_low_o),
        .pre_en_o   (pre_en),
        .pre_clr_o  (pre_clr),
        .rise_o     (scl_rise_o),
        .mid_o      (scl_mid_o),
        .fall_o     (scl_fall_o),
        .expo_o     (expo),
        .state_o    (st),
        .lat_o      (lat)
    );
endmodule

// File: rtl/scl_tg_chk.sv
`timescale 1ns/1ps
module scl_tg_chk
    import scl_tg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       run_i,
    input logic       scl_line_i,
    input logic       scl_drive_low_o,
    input logic       scl_rise_o,
    input logic       scl_mid_o,
    input logic       scl_fall_o,
    input tg_state_t  st,
    input tg_timing_t lat
);
    // R5
    rise_seen_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |-> (!scl_drive_low_o && scl_line_i));

    // R6
    mid_seen_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_mid_o |-> (!scl_drive_low_o && scl_line_i));

    // R7
    fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |=> scl_drive_low_o);

    // R2
    low_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low_o) |-> $past(scl_fall_o || (st == ST_IDLE)));

    // R4
    stretch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RELEASE && !scl_line_i) |-> (!scl_rise_o && !scl_mid_o && !scl_fall_o));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(scl_drive_low_o) |-> $stable(lat));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !run_i) |=> (st == ST_IDLE && !scl_drive_low_o));
endmodule

bind scl_timing_gen scl_tg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run_i),
    .scl_line_i     (scl_line_i),
    .scl_drive_low_o(scl_drive_low_o),
    .scl_rise_o     (scl_rise_o),
    .scl_mid_o      (scl_mid_o),
    .scl_fall_o     (scl_fall_o),
    .st             (st),
    .lat            (lat)
);

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [19:0] word = '0;
    logic        stretch = 1'b0;
    logic        line;
    logic        drive_low, rise, mid, fall;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    // wired-AND SCL: released only if nobody pulls it low
    assign line = !drive_low && !stretch;

    scl_timing_gen u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run),
        .timing_word_i  (word),
        .scl_line_i     (line),
        .scl_drive_low_o(drive_low),
        .scl_rise_o     (rise),
        .scl_mid_o      (mid),
        .scl_fall_o     (fall)
    );

    function automatic int low_len(input logic [19:0] w);
        return (int'(w[15:12]) + 1) << w[3:0];
    endfunction
    function automatic int high_len(input logic [19:0] w);
        return (int'(w[19:16]) + 1) << w[3:0];
    endfunction
    function automatic int mid_at(input logic [19:0] w);
        return ((int'(w[19:16]) >> 1) + 1) << w[3:0];
    endfunction
    function automatic logic [19:0] mk(input int hi, input int lo, input int junk, input int b);
        return {hi[3:0], lo[3:0], junk[7:0], b[3:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Measures one period starting at a negedge with drive_low asserted.
    task automatic meas(input logic [19:0] w, input logic [19:0] nxt, input int s, input bit stop);
        int lo_c = 0, hi_c = 0, in_low = 0;
        int r_n = 0, m_n = 0, f_n = 0, r_pos = 0, m_pos = 0, f_pos = 0;
        int limit;
        word = nxt;             // R8: new word written after the low phase began
        stretch = (s > 0);
        while (drive_low && lo_c < 40000) begin
            lo_c++;
            if (rise || mid || fall) in_low++;
            @(negedge clk);
        end
        limit = s + high_len(w) + 16;
        while (!drive_low && hi_c < limit) begin
            hi_c++;
            if (rise) begin r_n++; r_pos = hi_c; end
            if (mid)  begin m_n++; m_pos = hi_c; end
            if (fall) begin f_n++; f_pos = hi_c; end
            if (s > 0 && hi_c == s) begin
                @(posedge clk);
                #1 stretch = 1'b0;
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
        stretch = 1'b0;
        chk(lo_c == low_len(w), "R1 R2", "low length", lo_c, low_len(w));
        chk(in_low == 0, "R7", "strobes during low", in_low, 0);
        chk(r_n == 1 && r_pos == s + 1, "R4 R5", "rise position", r_pos, s + 1);
        chk(m_n == 1 && m_pos == s + mid_at(w), "R6", "mid position", m_pos, s + mid_at(w));
        if (stop) begin
            chk(hi_c == limit, "R9", "released after stop", hi_c, limit);
            chk(f_n == 0, "R9", "fall strobes after stop", f_n, 0);
        end else begin
            chk(hi_c == s + high_len(w), "R3 R4 R8", "released length", hi_c, s + high_len(w));
            chk(f_n == 1 && f_pos == hi_c, "R7", "fall position", f_pos, hi_c);
        end
    endtask

    task automatic idle_quiet(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drive_low || rise || mid || fall) bad++;
        end
        chk(bad == 0, req, "idle cycles with activity", bad, 0);
    endtask

    initial begin
        logic [19:0] cur, nxt;
        void'($urandom(32'h5A17));

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!drive_low && !rise && !mid && !fall, "R10", "outputs in reset",
            int'({drive_low, rise, mid, fall}), 0);
        rst_n = 1'b1;
        idle_quiet(20, "R10");

        // R9: start from idle, drive low on the first edge
        cur = mk(0, 0, 8'hA5, 0);
        word = cur;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        chk(drive_low == 1'b1, "R9", "drive low after start", int'(drive_low), 1);

        // directed corners: minimum, maximum fields, mid odd/even, large base, stretching
        nxt = mk(15, 15, 8'h3C, 2); meas(cur, nxt, 0, 0); cur = nxt;
        nxt = mk(1, 0, 8'hFF, 0);   meas(cur, nxt, 0, 0); cur = nxt;
        nxt = mk(7, 3, 8'h00, 7);   meas(cur, nxt, 4, 0); cur = nxt;
        nxt = mk(2, 9, 8'h81, 1);   meas(cur, nxt, 1, 0); cur = nxt;

        // constrained random periods
        for (int i = 0; i < 60; i++) begin
            int s;
            nxt = mk($urandom_range(0, 15), $urandom_range(0, 15),
                     $urandom_range(0, 255), $urandom_range(0, 4));
            s = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 6) : 0;
            meas(cur, nxt, s, 0);
            cur = nxt;
        end

        // R9: stop during the low phase, period completes, then idle
        run = 1'b0;
        meas(cur, cur, 0, 1);
        idle_quiet(12, "R9");

        // R9: restart gives a full first period
        cur = mk(4, 6, 8'h5A, 3);
        word = cur;
        run = 1'b1;
        @(negedge clk);
        chk(drive_low == 1'b1, "R9", "drive low after restart", int'(drive_low), 1);
        meas(cur, mk(0, 0, 0, 0), 2, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PER * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R9 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule